// File: doc/BRIEF.md
# Melody step sequencer with tone output

This block plays back a tune held as a list of 8-bit steps in a 64-word RAM. Each step carries a length code in its upper three bits and a pitch code in its lower five. The sequencer fetches one step at a time through a synchronous RAM read port. It holds the step for a time set by the length code and the tempo code. While the step is a note, it drives a square wave whose half-period comes from a fixed divider table.

The system clock is taken as the 131.072 kHz tone clock. A reference tick (32.768 kHz in the default setting) is `REF_DIV` clocks long. A sixteenth-note unit is `UNIT_REF` reference ticks times the tempo divider. Playback runs and repeats for as long as the play level is high. After the play level rises there is a fixed start delay. When the play level falls, playback halts at once and the output goes low. A special end word sends the step pointer back to address 0. A tie code lengthens the sounding note without restarting its waveform.

Top module: `melody_seq`

## Requirements
- R1: A step word is {len[2:0], pitch[4:0]}. The exact word 8'h5F is the end word: it holds no time of its own, the address returns to 0, and the next step is read from address 0 two clocks later. Words placed after it are never read.
- R2: Pitch codes 1 to 27 give these half-periods in clocks, in code order: 188,177,167,158,149,141,133,125,118,112,105,99,94,89,84,79,74,70,66,63,59,56,53,50,47,44,42. The output inverts every half-period clocks.
- R3: Pitch code 0, the unused codes 28 and 29, and code 31 in any word other than the end word are silent steps. The output stays low for the whole step.
- R4: Pitch code 30 is a tie. The pitch and the waveform phase carry on unchanged from the previous step. Only the new length applies.
- R5: A step with a sounding pitch starts with the output low and its half-period count at zero, on the clock edge that loads it.
- R6: Length codes 0..7 are 1,2,3,4,6,8,12,16 sixteenth units. A step lasts units × tempo divider × UNIT_REF × REF_DIV clocks, plus two clocks for the fetch of the next step.
- R7: The tempo code is read when each step is loaded. Codes 3..31 give divider code+1. Codes 0..2 act as divider 4.
- R8: The first step is loaded from address 0 on the edge that comes START_REF × REF_DIV + 2 edges after the first edge on which play is sampled high.
- R9: On any edge where play is sampled low, the output goes low and the address returns to 0. The next rise of play starts over, with the full start delay, from address 0.
- R10: With no end word present, the address steps from 63 back to 0 and playback continues.
- R11: Synchronous reset leaves the output low and the address at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock (131.072 kHz in the default setting) |
| rst | input | 1 | Synchronous active-high reset |
| play_i | input | 1 | Play level: high runs and repeats, low stops at once |
| tempo_i | input | 5 | Tempo code, read at each step load |
| ram_addr_o | output | ADDR_W | Step RAM read address |
| ram_data_i | input | 8 | Step RAM read data, one clock after the address |
| tone_o | output | 1 | Square-wave tone output |

## Verification
A wrong step address shows on the RAM address port at the next load edge. One step later it also shows as a wrong pitch or length on the tone pin. A wrong duration or start-delay count moves every later toggle, so the tone pin drifts from the model within one half-period after the misplaced load. A lost tie or a missing phase restart appears as a toggle displaced within the first half-period of the affected step. A gating fault on stop appears on the very edge that samples play low.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int WORD_W  = 8;
  localparam int PITCH_W = 5;
  localparam int LEN_W   = 3;
  localparam int HALF_W  = 8;
  localparam int TDIV_W  = 6;
  localparam int UNITS_W = 5;

  localparam logic [WORD_W-1:0]  END_WORD  = 8'h5F;
  localparam logic [PITCH_W-1:0] TIE_CODE  = 5'd30;
  localparam logic [PITCH_W-1:0] TEMPO_LOW = 5'd3;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_DELAY,
    SQ_FETCH,
    SQ_DECODE,
    SQ_HOLD
  } seq_state_t;

  // half-period of each pitch in tone clocks; 0 means silent
  function automatic logic [HALF_W-1:0] note_half_period(input logic [PITCH_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      5'd1:  h = 8'd188;
      5'd2:  h = 8'd177;
      5'd3:  h = 8'd167;
      5'd4:  h = 8'd158;
      5'd5:  h = 8'd149;
      5'd6:  h = 8'd141;
      5'd7:  h = 8'd133;
      5'd8:  h = 8'd125;
      5'd9:  h = 8'd118;
      5'd10: h = 8'd112;
      5'd11: h = 8'd105;
      5'd12: h = 8'd99;
      5'd13: h = 8'd94;
      5'd14: h = 8'd89;
      5'd15: h = 8'd84;
      5'd16: h = 8'd79;
      5'd17: h = 8'd74;
      5'd18: h = 8'd70;
      5'd19: h = 8'd66;
      5'd20: h = 8'd63;
      5'd21: h = 8'd59;
      5'd22: h = 8'd56;
      5'd23: h = 8'd53;
      5'd24: h = 8'd50;
      5'd25: h = 8'd47;
      5'd26: h = 8'd44;
      5'd27: h = 8'd42;
      default: h = 8'd0;
    endcase
    return h;
  endfunction

  // step length in sixteenth units
  function automatic logic [UNITS_W-1:0] len_units(input logic [LEN_W-1:0] code);
    logic [UNITS_W-1:0] u;
    case (code)
      3'd0: u = 5'd1;
      3'd1: u = 5'd2;
      3'd2: u = 5'd3;
      3'd3: u = 5'd4;
      3'd4: u = 5'd6;
      3'd5: u = 5'd8;
      3'd6: u = 5'd12;
      default: u = 5'd16;
    endcase
    return u;
  endfunction

  function automatic logic [TDIV_W-1:0] tempo_divider(input logic [PITCH_W-1:0] code);
    return (code < TEMPO_LOW) ? 6'd4 : ({1'b0, code} + 6'd1);
  endfunction

endpackage

// File: rtl/mseq_step_decode.sv
module mseq_step_decode
  import mseq_pkg::*;
#(
  parameter int DUR_W     = 20,
  parameter int UNIT_CLKS = 1536
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [PITCH_W-1:0] tempo_i,
  output logic               is_end_o,
  output logic               is_tie_o,
  output logic [HALF_W-1:0]  half_o,
  output logic [DUR_W-1:0]   dur_o
);

  logic [PITCH_W-1:0] pitch;
  logic [LEN_W-1:0]   len;
  logic [31:0]        prod;

  always_comb begin
    pitch    = word_i[PITCH_W-1:0];
    len      = word_i[WORD_W-1:PITCH_W];
    is_end_o = (word_i == END_WORD);
    is_tie_o = (pitch == TIE_CODE);
    half_o   = note_half_period(pitch);
    prod     = 32'(len_units(len)) * 32'(tempo_divider(tempo_i)) * 32'(UNIT_CLKS);
    dur_o    = prod[DUR_W-1:0];
  end

endmodule

// File: rtl/mseq_step_ctrl.sv
module mseq_step_ctrl
  import mseq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 20,
  parameter int START_CLKS = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              play_i,
  input  logic              is_end_i,
  input  logic [CNT_W-1:0]  dur_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              step_load_o,
  output logic              playing_o
);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (rst || !play_i) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      addr  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          state <= SQ_DELAY;
          cnt   <= CNT_W'(START_CLKS - 1);
        end
        SQ_DELAY: begin
          if (cnt == '0) state <= SQ_FETCH;
          else           cnt   <= cnt - 1'b1;
        end
        SQ_FETCH: state <= SQ_DECODE;
        SQ_DECODE: begin
          if (is_end_i) begin
            addr  <= '0;
            state <= SQ_FETCH;
          end else begin
            addr  <= addr + 1'b1;
            cnt   <= dur_i - 1'b1;
            state <= SQ_HOLD;
          end
        end
        SQ_HOLD: begin
          if (cnt == '0) state <= SQ_FETCH;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign addr_o      = addr;
  assign step_load_o = (state == SQ_DECODE) && !is_end_i;
  assign playing_o   = (state == SQ_FETCH) || (state == SQ_DECODE) || (state == SQ_HOLD);

  // R1: an end word sends the pointer back to the first step
  a_r1_end_wraps: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DECODE && is_end_i) |=> (addr == '0));

  // R10: each loaded step advances the pointer by one, modulo the RAM depth
  a_r10_addr_step: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DECODE && !is_end_i && play_i) |=> (addr == $past(addr) + 1'b1));

  // R8: the pointer sits at 0 throughout the start delay
  a_r8_delay_addr0: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DELAY) |-> (addr == '0));

  // R6: every loaded step has a non-zero duration
  a_r6_dur_nonzero: assert property (@(posedge clk) disable iff (rst)
    step_load_o |-> (dur_i != '0));

endmodule

// File: rtl/mseq_tone_gen.sv
module mseq_tone_gen
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              tie_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tone_o
);

  logic [HALF_W-1:0] pitch;
  logic [HALF_W-1:0] tcnt;
  logic              tone;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pitch <= '0;
      tcnt  <= '0;
      tone  <= 1'b0;
    end else if (load_i && !tie_i) begin
      pitch <= half_i;
      tcnt  <= '0;
      tone  <= 1'b0;
    end else if (pitch != '0) begin
      if (tcnt == pitch - 1'b1) begin
        tcnt <= '0;
        tone <= ~tone;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign tone_o = tone;

  // R3: a silent step never drives the output high
  a_r3_rest_quiet: assert property (@(posedge clk) disable iff (rst)
    (pitch == '0) |-> !tone);

  // R2: the half-period count stays below the selected divider
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    (pitch != '0) |-> (tcnt < pitch));

  // R4: a tie keeps the sounding pitch
  a_r4_tie_keeps_pitch: assert property (@(posedge clk) disable iff (rst)
    (run_i && load_i && tie_i) |=> (pitch == $past(pitch)));

endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int REF_DIV   = 4,
  parameter int UNIT_REF  = 384,
  parameter int START_REF = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              play_i,
  input  logic [4:0]        tempo_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic              tone_o
);

  localparam int UNIT_CLKS  = UNIT_REF * REF_DIV;
  localparam int START_CLKS = START_REF * REF_DIV;
  localparam int MAX_DUR    = 16 * 32 * UNIT_CLKS;
  localparam int CNT_MAX    = (MAX_DUR > START_CLKS) ? MAX_DUR : START_CLKS;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic              is_end;
  logic              is_tie;
  logic [HALF_W-1:0] half;
  logic [CNT_W-1:0]  dur;
  logic              step_load;
  logic              playing;
  logic              run;

  mseq_step_decode #(
    .DUR_W     (CNT_W),
    .UNIT_CLKS (UNIT_CLKS)
  ) u_dec (
    .word_i   (ram_data_i),
    .tempo_i  (tempo_i),
    .is_end_o (is_end),
    .is_tie_o (is_tie),
    .half_o   (half),
    .dur_o    (dur)
  );

  mseq_step_ctrl #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .START_CLKS (START_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .play_i      (play_i),
    .is_end_i    (is_end),
    .dur_i       (dur),
    .addr_o      (ram_addr_o),
    .step_load_o (step_load),
    .playing_o   (playing)
  );

  assign run = playing && play_i;

  mseq_tone_gen u_tone (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .load_i (step_load),
    .tie_i  (is_tie),
    .half_i (half),
    .tone_o (tone_o)
  );

  // R9: dropping play silences the output and rewinds on the same edge
  a_r9_stop_now: assert property (@(posedge clk) disable iff (rst)
    !play_i |=> (!tone_o && ram_addr_o == '0));

endmodule

// File: tb/sim_melody_seq.sv
`timescale 1ns/1ps
module sim_melody_seq;

  localparam int ADDR_W    = 6;
  localparam int REF_DIV   = 2;
  localparam int UNIT_REF  = 3;
  localparam int START_REF = 10;
  localparam int UNIT_CLKS = UNIT_REF * REF_DIV;
  localparam int START_CLK = START_REF * REF_DIV;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              play = 1'b0;
  logic [4:0]        tempo = 5'd4;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_data = 8'h00;
  logic              tone;

  logic [7:0] mem [64];

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    done = 0;
  string phase = "R11 reset";

  // reference model state
  int       m_mode = 0;
  int       m_left = 0;
  int       m_addr = 0;
  int       m_p = 0;
  int       m_pc = 0;
  bit       m_tone = 0;

  always #2.5 clk = ~clk;

  melody_seq #(
    .ADDR_W    (ADDR_W),
    .REF_DIV   (REF_DIV),
    .UNIT_REF  (UNIT_REF),
    .START_REF (START_REF)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .play_i     (play),
    .tempo_i    (tempo),
    .ram_addr_o (ram_addr),
    .ram_data_i (ram_data),
    .tone_o     (tone)
  );

  // synchronous step RAM
  always @(posedge clk) ram_data <= mem[ram_addr];

  // R2 half-period table
  function automatic int half_of(input int code);
    int t [27] = '{188,177,167,158,149,141,133,125,118,112,105,99,94,89,
                   84,79,74,70,66,63,59,56,53,50,47,44,42};
    if (code >= 1 && code <= 27) return t[code-1];
    return 0;
  endfunction

  // R6 / R7 step length in clocks
  function automatic int dur_of(input int lcode, input int tcode);
    int u [8] = '{1,2,3,4,6,8,12,16};
    int d;
    d = (tcode < 3) ? 4 : tcode + 1;
    return u[lcode] * d * UNIT_CLKS;
  endfunction

  always @(posedge clk) begin
    bit ld;
    bit tie;
    int np;
    logic [7:0] w;
    started = 1;
    ld = 0; tie = 0; np = 0;
    if (rst || !play) begin
      m_mode = 0; m_tone = 0; m_addr = 0; m_p = 0; m_pc = 0;
    end else if (m_mode == 0) begin
      m_mode = 1;
      m_left = START_CLK + 2;
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        w = mem[m_addr];
        m_mode = 2;
        if (w == 8'h5F) begin
          m_addr = 0;
          m_left = 2;
        end else begin
          ld  = 1;
          tie = (w[4:0] == 5'd30);
          np  = half_of(int'(w[4:0]));
          m_left = dur_of(int'(w[7:5]), int'(tempo)) + 2;
          m_addr = (m_addr + 1) % 64;
        end
      end
      if (m_mode == 2) begin
        if (ld && !tie) begin
          m_p = np; m_pc = 0; m_tone = 0;
        end else if (m_p != 0) begin
          m_pc = m_pc + 1;
          if (m_pc == m_p) begin
            m_pc = 0;
            m_tone = !m_tone;
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (tone !== m_tone || int'(ram_addr) != m_addr) begin
        n_bad++;
        if (n_bad < 20)
          $display("FAIL %s: tone=%0b exp=%0b addr=%0d exp=%0d at %0t",
                   phase, tone, m_tone, ram_addr, m_addr, $time);
      end
    end
  end

  task automatic idle(input int n);
    play = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input int n);
    play = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 64; i++) mem[i] = v;
  endtask

  initial begin
    fill(8'h00);
    repeat (4) @(negedge clk);
    // R11: reset state checked explicitly
    n_cmp++;
    if (tone !== 1'b0 || ram_addr !== '0) begin
      n_bad++;
      $display("FAIL R11: tone=%0b addr=%0d exp 0/0", tone, ram_addr);
    end
    rst = 1'b0;
    @(negedge clk);

    // notes, tie, rest, end word with ignored word after it
    phase = "R1 R2 R4 R5 R6 R8";
    fill(8'h00);
    mem[0] = {3'd5, 5'd5};
    mem[1] = {3'd3, 5'd30};
    mem[2] = {3'd2, 5'd0};
    mem[3] = {3'd4, 5'd27};
    mem[4] = {3'd1, 5'd8};
    mem[5] = {3'd6, 5'd30};
    mem[6] = 8'h5F;
    mem[7] = {3'd7, 5'd1};
    tempo = 5'd7;
    run(4000);

    // tempo changes while playing, including the clamped low codes
    phase = "R7";
    tempo = 5'h1F;
    run(1500);
    tempo = 5'd1;
    run(1200);
    tempo = 5'd0;
    run(600);

    // stop in the middle of a note, then restart from the top
    phase = "R9";
    tempo = 5'd5;
    idle(1);
    n_cmp++;
    if (tone !== 1'b0 || ram_addr !== '0) begin
      n_bad++;
      $display("FAIL R9: tone=%0b addr=%0d exp 0/0", tone, ram_addr);
    end
    run(300);
    idle(7);
    run(900);

    // silent codes interleaved with notes
    phase = "R3";
    idle(3);
    fill(8'h00);
    mem[0] = {3'd3, 5'd12};
    mem[1] = {3'd2, 5'd28};
    mem[2] = {3'd2, 5'd30};
    mem[3] = {3'd3, 5'd20};
    mem[4] = {3'd2, 5'd29};
    mem[5] = {3'd4, 5'd17};
    mem[6] = 8'h7F;
    mem[7] = {3'd3, 5'd2};
    mem[8] = 8'h1F;
    mem[9] = 8'h5F;
    tempo = 5'd4;
    run(2500);

    // 64 steps, no end word
    phase = "R10";
    idle(3);
    for (int i = 0; i < 64; i++) mem[i] = {3'd0, 5'((i % 27) + 1)};
    tempo = 5'd3;
    run(3600);

    // end word at the first address keeps the output silent
    phase = "R1";
    idle(3);
    fill(8'h00);
    mem[0] = 8'h5F;
    mem[1] = {3'd7, 5'd5};
    run(300);
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (%s): run did not end, exp completion", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule